// File: doc/BRIEF.md
# Shift-Capable Integer ALU with Function Decoder

This block is the arithmetic unit of a single-cycle integer datapath, together with the small decoder that turns an operation class and a function field into an ALU command. The main instruction decoder supplies a 2-bit class. One class value forces an addition, used for address generation and immediate adds. Another forces a subtraction, used for equality branches. The remaining values hand the choice to the 6-bit function field of a register-format instruction.

The block extends the usual add, subtract, AND, OR and signed compare with four logical shifts. Two of them take their distance from the 5-bit shift-amount field of the instruction. The other two take it from the low bits of the first register operand. Every shift moves the second operand. All logic is combinational, and results appear in the same cycle as the operands. A zero flag accompanies every result.

Top module: `shift_alu`

## Requirements
- R1: Class 00 performs `src_a + src_b` (modulo 2^32) whatever the function field holds.
- R2: Class 01 performs `src_a - src_b` (modulo 2^32) whatever the function field holds.
- R3: Under class 10 or 11, the function codes give these operations: 0x20 is add, 0x22 is subtract (a minus b), 0x24 is bitwise AND and 0x25 is bitwise OR.
- R4: Function 0x2A yields 1 when `src_a` is less than `src_b` as signed two's-complement numbers, and yields 0 otherwise. This includes equal operands.
- R5: Function 0x00 shifts `src_b` left by `shamt` and fills with zeros. `src_a` has no effect on the result.
- R6: Function 0x02 shifts `src_b` right by `shamt` and fills with zeros, never with the sign bit.
- R7: Function 0x04 shifts `src_b` left by `src_a[4:0]` and fills with zeros. `shamt` has no effect on the result.
- R8: Function 0x06 shifts `src_b` right by `src_a[4:0]` and fills with zeros. `shamt` has no effect on the result.
- R9: The variable shifts ignore `src_a[31:5]`, so any distance of 32 or more wraps modulo 32.
- R10: `zero` is 1 exactly when `result` is all zeros, for every operation.
- R11: An unlisted function code under class 10 or 11 performs an addition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| alu_class | input | 2 | Operation class from the main decoder |
| funct | input | 6 | Function field of a register-format instruction |
| shamt | input | 5 | Constant shift distance taken from the instruction |
| src_a | input | 32 | First register operand; its low bits also give the variable shift distance |
| src_b | input | 32 | Second operand, either a register or an immediate; this is the value that shifts move |
| result | output | 32 | Operation result |
| zero | output | 1 | High when the result is all zeros |

## Verification
The zero flag and a shift can come into play together whenever a shift pushes every set bit out of the word. The stimulus provokes this by shifting a value whose only set bits are in its low half right by sixteen, and by testing an equal-operand compare. In both cases the bench expects a zero result and a raised flag in the same sample. It also pairs each distance source with a misleading value in the unused source, such as a nonzero `src_a` for a constant shift, a nonzero `shamt` for a variable shift, and high bits set in `src_a`. Any case where the wrong source leaks into the result then shows up as a wrong result.

// File: rtl/shift_alu_pkg.sv
package shift_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND  = 4'b0000,
    OP_OR   = 4'b0001,
    OP_ADD  = 4'b0010,
    OP_SUB  = 4'b0110,
    OP_SLT  = 4'b0111,
    OP_SLLV = 4'b1000,
    OP_SRLV = 4'b1001,
    OP_SLL  = 4'b1010,
    OP_SRL  = 4'b1011
  } alu_op_e;

  localparam logic [1:0] CLS_ADD = 2'b00;
  localparam logic [1:0] CLS_SUB = 2'b01;

  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_SLLV = 6'h04;
  localparam logic [5:0] FN_SRLV = 6'h06;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_SLT  = 6'h2A;

endpackage

// File: rtl/shift_alu_dec.sv
module shift_alu_dec
  import shift_alu_pkg::*;
(
  input  logic [1:0] alu_class,
  input  logic [5:0] funct,
  output alu_op_e    op
);

  alu_op_e fn_op;

  // function-field decode; unlisted codes fall back to add
  always_comb begin
    case (funct)
      FN_ADD:  fn_op = OP_ADD;
      FN_SUB:  fn_op = OP_SUB;
      FN_AND:  fn_op = OP_AND;
      FN_OR:   fn_op = OP_OR;
      FN_SLT:  fn_op = OP_SLT;
      FN_SLL:  fn_op = OP_SLL;
      FN_SRL:  fn_op = OP_SRL;
      FN_SLLV: fn_op = OP_SLLV;
      FN_SRLV: fn_op = OP_SRLV;
      default: fn_op = OP_ADD;
    endcase
  end

  // class override has priority over the function field
  always_comb begin
    case (alu_class)
      CLS_ADD: op = OP_ADD;
      CLS_SUB: op = OP_SUB;
      default: op = fn_op;
    endcase
  end

endmodule

// File: rtl/shift_alu_amt.sv
module shift_alu_amt
  import shift_alu_pkg::*;
#(
  parameter int SHW = 5
) (
  input  alu_op_e        op,
  input  logic [SHW-1:0] shamt,
  input  logic [SHW-1:0] rs_low,
  output logic [SHW-1:0] amt
);

  // bit 1 of a shift code marks the constant-distance forms
  logic use_const;

  always_comb begin
    use_const = op[1];
    amt       = use_const ? shamt : rs_low;
  end

endmodule

// File: rtl/shift_alu_core.sv
module shift_alu_core
  import shift_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SHW    = 5
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [SHW-1:0]    amt,
  output logic [DATA_W-1:0] y,
  output logic              y_zero
);

  logic              inv_b;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] sum;
  logic              less;
  logic [DATA_W-1:0] shl;
  logic [DATA_W-1:0] shr;

  // one adder serves add, subtract and compare
  always_comb begin
    inv_b = (op == OP_SUB) || (op == OP_SLT);
    b_eff = b ^ {DATA_W{inv_b}};
    sum   = a + b_eff + {{(DATA_W-1){1'b0}}, inv_b};
  end

  // signed compare: differing signs decide directly, else the difference sign
  always_comb begin
    if (a[DATA_W-1] != b[DATA_W-1]) less = a[DATA_W-1];
    else                            less = sum[DATA_W-1];
  end

  always_comb begin
    shl = b << amt;
    shr = b >> amt;
  end

  always_comb begin
    case (op)
      OP_AND:           y = a & b;
      OP_OR:            y = a | b;
      OP_SLT:           y = {{(DATA_W-1){1'b0}}, less};
      OP_SLL, OP_SLLV:  y = shl;
      OP_SRL, OP_SRLV:  y = shr;
      default:          y = sum;
    endcase
    y_zero = ~|y;
  end

endmodule

// File: rtl/shift_alu.sv
module shift_alu
  import shift_alu_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int SHW    = $clog2(DATA_W)
) (
  input  logic [1:0]        alu_class,
  input  logic [5:0]        funct,
  input  logic [SHW-1:0]    shamt,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic [DATA_W-1:0] result,
  output logic              zero
);

  alu_op_e        op;
  logic [SHW-1:0] amt;

  shift_alu_dec u_dec (
    .alu_class (alu_class),
    .funct     (funct),
    .op        (op)
  );

  shift_alu_amt #(.SHW(SHW)) u_amt (
    .op     (op),
    .shamt  (shamt),
    .rs_low (src_a[SHW-1:0]),
    .amt    (amt)
  );

  shift_alu_core #(.DATA_W(DATA_W), .SHW(SHW)) u_core (
    .op     (op),
    .a      (src_a),
    .b      (src_b),
    .amt    (amt),
    .y      (result),
    .y_zero (zero)
  );

endmodule

// File: rtl/shift_alu_chk.sv
module shift_alu_chk #(
  parameter  int DATA_W = 32,
  localparam int SHW    = $clog2(DATA_W)
) (
  input logic [1:0]        alu_class,
  input logic [5:0]        funct,
  input logic [SHW-1:0]    shamt,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic [DATA_W-1:0] result,
  input logic              zero
);

  logic fn_cls;

  always_comb begin
    fn_cls = alu_class[1];

    // R1: forced add class
    p_class_add_r1: assert (alu_class != 2'b00 || result == src_a + src_b)
      else $error("class add mismatch");
    // R2: forced subtract class
    p_class_sub_r2: assert (alu_class != 2'b01 || result == src_a - src_b)
      else $error("class sub mismatch");
    // R4: compare yields a single bit
    p_slt_bit_r4: assert (!(fn_cls && funct == 6'h2A) || result[DATA_W-1:1] == '0)
      else $error("compare result wider than one bit");
    // R5: constant left shift
    p_sll_r5: assert (!(fn_cls && funct == 6'h00) || result == (src_b << shamt))
      else $error("constant left shift mismatch");
    // R8 and R9: variable right shift uses low bits of src_a only
    p_srlv_r9: assert (!(fn_cls && funct == 6'h06) || result == (src_b >> src_a[SHW-1:0]))
      else $error("variable right shift mismatch");
    // R10: zero flag tracks the result
    p_zero_flag_r10: assert (zero == (result == '0))
      else $error("zero flag mismatch");
  end

endmodule

bind shift_alu shift_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .alu_class (alu_class),
  .funct     (funct),
  .shamt     (shamt),
  .src_a     (src_a),
  .src_b     (src_b),
  .result    (result),
  .zero      (zero)
);

// File: tb/shift_alu_tb.sv
module shift_alu_tb;

  logic        clk;
  logic [1:0]  alu_class;
  logic [5:0]  funct;
  logic [4:0]  shamt;
  logic [31:0] src_a;
  logic [31:0] src_b;
  logic [31:0] result;
  logic        zero;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  shift_alu u_dut (
    .alu_class (alu_class),
    .funct     (funct),
    .shamt     (shamt),
    .src_a     (src_a),
    .src_b     (src_b),
    .result    (result),
    .zero      (zero)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [1:0]  cls;
    logic [5:0]  fn;
    logic [4:0]  sh;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] exp;
    logic        ez;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{2'b00, 6'h22, 5'd0,  32'd5,          32'd7,          32'd12,         1'b0, 4'd1},  // R1
    '{2'b00, 6'h00, 5'd3,  32'd1,          32'd2,          32'd3,          1'b0, 4'd1},  // R1 shift code ignored
    '{2'b01, 6'h20, 5'd0,  32'd9,          32'd9,          32'd0,          1'b1, 4'd2},  // R2
    '{2'b10, 6'h20, 5'd0,  32'hFFFF_FFFF,  32'd1,          32'd0,          1'b1, 4'd3},  // R3 add wraps
    '{2'b10, 6'h22, 5'd0,  32'd3,          32'd5,          32'hFFFF_FFFE,  1'b0, 4'd3},  // R3 sub
    '{2'b10, 6'h24, 5'd0,  32'hF0F0_F0F0,  32'hFF00_FF00,  32'hF000_F000,  1'b0, 4'd3},  // R3 and
    '{2'b10, 6'h25, 5'd0,  32'h0000_00F0,  32'h0000_0F00,  32'h0000_0FF0,  1'b0, 4'd3},  // R3 or
    '{2'b10, 6'h2A, 5'd0,  32'hFFFF_FFFF,  32'd1,          32'd1,          1'b0, 4'd4},  // R4 -1 < 1
    '{2'b10, 6'h2A, 5'd0,  32'd1,          32'hFFFF_FFFF,  32'd0,          1'b1, 4'd4},  // R4 1 < -1 false
    '{2'b10, 6'h00, 5'd4,  32'hDEAD_BEEF,  32'h0000_1234,  32'h0001_2340,  1'b0, 4'd5},  // R5
    '{2'b10, 6'h00, 5'd31, 32'd7,          32'd3,          32'h8000_0000,  1'b0, 4'd5},  // R5 max distance
    '{2'b10, 6'h02, 5'd8,  32'd1,          32'h8000_00FF,  32'h0080_0000,  1'b0, 4'd6},  // R6 zero fill
    '{2'b10, 6'h04, 5'd17, 32'd5,          32'd1,          32'd32,         1'b0, 4'd7},  // R7
    '{2'b10, 6'h06, 5'd9,  32'd4,          32'hF000_0000,  32'h0F00_0000,  1'b0, 4'd8},  // R8
    '{2'b11, 6'h06, 5'd0,  32'd1,          32'd8,          32'd4,          1'b0, 4'd8},  // R8 class 11
    '{2'b10, 6'h04, 5'd0,  32'd33,         32'd1,          32'd2,          1'b0, 4'd9},  // R9 wraps
    '{2'b10, 6'h06, 5'd0,  32'd32,         32'hABCD_0000,  32'hABCD_0000,  1'b0, 4'd9},  // R9 wraps to 0
    '{2'b10, 6'h02, 5'd16, 32'd0,          32'h0000_FFFF,  32'd0,          1'b1, 4'd10}, // R10 shift to zero
    '{2'b10, 6'h3F, 5'd0,  32'd2,          32'd3,          32'd5,          1'b0, 4'd11}  // R11 default add
  };

  task automatic apply_check(input logic [1:0] c, input logic [5:0] f,
                             input logic [4:0] s, input logic [31:0] a,
                             input logic [31:0] b, input logic [31:0] exp,
                             input logic ez, input int req);
    @(posedge clk);
    alu_class = c; funct = f; shamt = s; src_a = a; src_b = b;
    @(negedge clk);
    total++;
    if (result !== exp || zero !== ez) begin
      bad++;
      $display("FAIL R%0d: result=%h zero=%b expected result=%h zero=%b",
               req, result, zero, exp, ez);
    end
  endtask

  initial begin
    alu_class = 2'b00; funct = '0; shamt = '0; src_a = '0; src_b = '0;
    for (int i = 0; i < NV; i++) begin
      apply_check(TBL[i].cls, TBL[i].fn, TBL[i].sh, TBL[i].a, TBL[i].b,
                  TBL[i].exp, TBL[i].ez, int'(TBL[i].req));
    end
    // R5: zero distance passes src_b through unchanged
    apply_check(2'b10, 6'h00, 5'd0, 32'h1357_9BDF, 32'h2468_ACE0, 32'h2468_ACE0, 1'b0, 5);
    // R9: high bits of src_a are ignored, distance 3
    apply_check(2'b10, 6'h06, 5'd20, 32'hFFFF_FFE3, 32'h0000_0080, 32'h0000_0010, 1'b0, 9);
    // R4 with R10: equal operands compare false and raise zero
    apply_check(2'b11, 6'h2A, 5'd0, 32'h8000_0000, 32'h8000_0000, 32'd0, 1'b1, 4);
    // R6: top bit set must not propagate
    apply_check(2'b10, 6'h02, 5'd31, 32'd0, 32'hFFFF_FFFF, 32'd1, 1'b0, 6);
    // R2: subtract class overrides an OR function code
    apply_check(2'b01, 6'h25, 5'd0, 32'd0, 32'd1, 32'hFFFF_FFFF, 1'b0, 2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule